// File: doc/BRIEF.md
# Quadrature Encoder Pulse Divider

This block sits between an incremental encoder and a downstream consumer that needs a slower pulse rate. It takes the two channel levels, A and B, resynchronises them to the system clock and finds their rising edges. It then lowers the pulse rate by an 8-bit denominator. The denominator and two mode bits come from configuration switches that read 0 when closed, so the block inverts every switch bit before using it.

The mode bits decide what the second output carries. It can be a second divided channel, a static flag that reports which channel leads, or a registered copy of a direction level supplied on input B. The first output always carries channel A divided by the denominator. The switch setting is captured into registers every cycle. Any change to that setting clears all counting state, and so does the synchronous reset.

Top module: `qenc_rate_div`

## Requirements
- R1: The denominator N is the bitwise inverse of `ratio_sw_n`, and bit 0 is the least significant bit. Raw 8'hAA gives N = 85.
- R2: Mode bits are m1 = ~`mode_sw_n[0]` and m2 = ~`mode_sw_n[1]`. When m1 = 0 and m2 = 0, each output divides its own input. For N >= 2, an output first rises on the N-th rising edge of its input and then rises once every N rising edges. It falls on the rising edge that brings its internal count to N/2, rounded down.
- R3: When N is 0 or 1, each divided output follows its synchronised input level with no division.
- R4: When m1 = 0 and m2 = 1, `out_a` is input A divided. `out_b` is a flag that is sampled from B on each rising edge of A: 0 (A leads) if B is low, 1 (B leads) if B is high. The flag changes only on a rising edge of A.
- R5: When m1 = 1, m2 has no effect. `out_a` is input A divided, and `out_b` is the level of input B, registered.
- R6: A change on an input reaches the outputs on the third rising clock edge after the change. The path is two synchroniser flops followed by one output register.
- R7: A change in any switch bit clears the counters, the divided outputs, the direction register and the phase flag. The phase flag returns to its A-leads value (0), and both outputs are 0 on the following cycle.
- R8: While `srst` is high, the same state is cleared and both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder channel A level |
| enc_b | input | 1 | Encoder channel B level, or the direction level in direction mode |
| ratio_sw_n | input | 8 | Denominator switches, read as 0 when closed |
| mode_sw_n | input | 2 | Mode switches, read as 0 when closed |
| out_a | output | 1 | Channel A divided by N |
| out_b | output | 1 | Divided B, phase flag or direction, chosen by mode |

## Verification
Every result appears three clock edges after the input step that causes it. The bench holds each quadrature step for six cycles, so every output has settled before the next step and before any check. Output rising edges are counted at falling clock edges and compared with floor(R/N), where R is the number of A or B rising edges the bench produced. The latency requirement is checked directly: after a single step in pass-through mode, the output is sampled after the second edge, where it must still be low, and after the third edge, where it must be high. Configuration and reset tests change the setting part-way through a count and then look for an output level that only a cleared counter can produce.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;

   typedef enum logic [1:0] {
      QD_MODE_DIV   = 2'd0,
      QD_MODE_PHASE = 2'd1,
      QD_MODE_DIR   = 2'd2
   } qd_mode_e;

   // Switches read 0 when closed; bit 0 is m1, bit 1 is m2 after inversion.
   function automatic qd_mode_e qd_decode_mode(input logic [1:0] sw_n);
      logic m1;
      logic m2;
      m1 = ~sw_n[0];
      m2 = ~sw_n[1];
      if (m1)      return QD_MODE_DIR;
      else if (m2) return QD_MODE_PHASE;
      else         return QD_MODE_DIV;
   endfunction

endpackage

// File: rtl/qdiv_sync.sv
module qdiv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic srst,
   input  logic din,
   output logic lvl,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdiv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;
   logic              prev;

   always_ff @(posedge clk) begin
      if (srst) begin
         shreg <= '0;
         prev  <= 1'b0;
      end else begin
         shreg <= {shreg[STAGES-2:0], din};
         prev  <= shreg[STAGES-1];
      end
   end

   assign lvl  = shreg[STAGES-1];
   assign rise = shreg[STAGES-1] & ~prev;

endmodule

// File: rtl/qdiv_chan_div.sv
module qdiv_chan_div #(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               clr,
   input  logic               rise_evt,
   input  logic               lvl,
   input  logic [RATIO_W-1:0] ratio,
   output logic               div_out
);

   generate
      if (RATIO_W < 1 || RATIO_W > 16) begin : g_bad_width
         $error("qdiv_chan_div: RATIO_W out of range");
      end
   endgenerate

   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

   logic [RATIO_W-1:0] cnt;
   logic [RATIO_W-1:0] cnt_nxt;
   logic [RATIO_W-1:0] half;
   logic               pass;

   assign pass    = (ratio <= ONE);
   assign cnt_nxt = cnt + ONE;
   assign half    = ratio >> 1;

   always_ff @(posedge clk) begin
      if (srst || clr) begin
         cnt     <= '0;
         div_out <= 1'b0;
      end else if (pass) begin
         cnt     <= '0;
         div_out <= lvl;
      end else if (rise_evt) begin
         if (cnt == ratio - ONE) begin
            cnt     <= '0;
            div_out <= 1'b1;
         end else begin
            cnt <= cnt_nxt;
            if (cnt_nxt == half) div_out <= 1'b0;
         end
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (srst)
      !pass |-> (cnt < ratio));

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (srst)
      (!pass && !clr && !rise_evt) |=> $stable(div_out));

endmodule

// File: rtl/qdiv_phase.sv
module qdiv_phase (
   input  logic clk,
   input  logic srst,
   input  logic clr,
   input  logic a_rise,
   input  logic b_lvl,
   output logic b_leads
);

   always_ff @(posedge clk) begin
      if (srst || clr) b_leads <= 1'b0;
      else if (a_rise) b_leads <= b_lvl;
   end

   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (srst)
      (!a_rise && !clr) |=> $stable(b_leads));

endmodule

// File: rtl/qenc_rate_div.sv
module qenc_rate_div
   import qdiv_pkg::*;
#(
   parameter int RATIO_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               enc_a,
   input  logic               enc_b,
   input  logic [RATIO_W-1:0] ratio_sw_n,
   input  logic [1:0]         mode_sw_n,
   output logic               out_a,
   output logic               out_b
);

   localparam int NCH   = 2;
   localparam int CFG_W = RATIO_W + 2;

   logic [NCH-1:0]     raw_in;
   logic [NCH-1:0]     lvl;
   logic [NCH-1:0]     rise;
   logic [NCH-1:0]     div_q;
   logic [CFG_W-1:0]   cfg_now;
   logic [CFG_W-1:0]   cfg_q;
   logic               cfg_chg;
   logic [RATIO_W-1:0] ratio;
   qd_mode_e           mode;
   logic               dir_q;
   logic               b_leads;

   assign raw_in  = {enc_b, enc_a};
   assign cfg_now = {mode_sw_n, ratio_sw_n};
   assign cfg_chg = (cfg_now != cfg_q);
   assign ratio   = ~cfg_q[RATIO_W-1:0];
   assign mode    = qd_decode_mode(cfg_q[CFG_W-1:RATIO_W]);

   always_ff @(posedge clk) begin
      cfg_q <= cfg_now;
   end

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         qdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .srst (srst),
            .din  (raw_in[ch]),
            .lvl  (lvl[ch]),
            .rise (rise[ch])
         );
         qdiv_chan_div #(.RATIO_W(RATIO_W)) u_div (
            .clk      (clk),
            .srst     (srst),
            .clr      (cfg_chg),
            .rise_evt (rise[ch]),
            .lvl      (lvl[ch]),
            .ratio    (ratio),
            .div_out  (div_q[ch])
         );
      end
   endgenerate

   qdiv_phase u_phase (
      .clk     (clk),
      .srst    (srst),
      .clr     (cfg_chg),
      .a_rise  (rise[0]),
      .b_lvl   (lvl[1]),
      .b_leads (b_leads)
   );

   always_ff @(posedge clk) begin
      if (srst || cfg_chg) dir_q <= 1'b0;
      else                 dir_q <= lvl[1];
   end

   always_comb begin
      out_a = div_q[0];
      unique case (mode)
         QD_MODE_PHASE: out_b = b_leads;
         QD_MODE_DIR:   out_b = dir_q;
         default:       out_b = div_q[1];
      endcase
   end

   // R7
   cfg_clear_chk: assert property (@(posedge clk) disable iff (srst)
      cfg_chg |=> (!out_a && !out_b));

   // R5
   dir_follow_chk: assert property (@(posedge clk) disable iff (srst)
      (mode == QD_MODE_DIR && !cfg_chg) |=> (out_b == $past(lvl[1])));

   // R8
   reset_low_chk: assert property (@(posedge clk)
      srst |=> (!out_a && !out_b));

endmodule

// File: tb/qenc_rate_div_bench.sv
`timescale 1ns/1ps
module qenc_rate_div_bench;

   localparam int HOLD = 6;
   localparam logic [1:0] M_DIV   = 2'b11;
   localparam logic [1:0] M_PHASE = 2'b01;
   localparam logic [1:0] M_DIR   = 2'b10;
   localparam logic [1:0] M_DIR2  = 2'b00;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       enc_a = 1'b0;
   logic       enc_b = 1'b0;
   logic [7:0] ratio_sw_n = 8'hFF;
   logic [1:0] mode_sw_n = M_DIV;
   logic       out_a;
   logic       out_b;

   int errors = 0;
   int checks = 0;
   int rises_a = 0;
   int rises_b = 0;
   logic pa = 1'b0;
   logic pb = 1'b0;
   bit finished = 0;

   always #4 clk = ~clk;

   qenc_rate_div u_qenc_rate_div (
      .clk        (clk),
      .srst       (srst),
      .enc_a      (enc_a),
      .enc_b      (enc_b),
      .ratio_sw_n (ratio_sw_n),
      .mode_sw_n  (mode_sw_n),
      .out_a      (out_a),
      .out_b      (out_b)
   );

   always @(negedge clk) begin
      if (out_a && !pa) rises_a++;
      if (out_b && !pb) rises_b++;
      pa = out_a;
      pb = out_b;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [1:0] m, input int n);
      @(negedge clk);
      mode_sw_n  = m;
      ratio_sw_n = ~8'(n);
      hold();
   endtask

   // dir 0: A leads (A rises while B low); dir 1: B leads
   task automatic quad(input int n, input bit dir);
      for (int i = 0; i < n; i++) begin
         if (!dir) begin
            enc_a = 1'b1; hold(); enc_b = 1'b1; hold();
            enc_a = 1'b0; hold(); enc_b = 1'b0; hold();
         end else begin
            enc_b = 1'b1; hold(); enc_a = 1'b1; hold();
            enc_b = 1'b0; hold(); enc_a = 1'b0; hold();
         end
      end
   endtask

   task automatic pulse_a(input int n);
      for (int i = 0; i < n; i++) begin
         enc_a = 1'b1; hold(); enc_a = 1'b0; hold();
      end
   endtask

   task automatic t_reset();
      chk(out_a == 1'b0, "R8 reset out_a", out_a, 0);
      chk(out_b == 1'b0, "R8 reset out_b", out_b, 0);
   endtask

   task automatic t_ratio_decode();
      int ba, bb;
      // R1: raw 8'hAA -> 85
      @(negedge clk);
      mode_sw_n = M_DIV; ratio_sw_n = 8'hAA; hold();
      ba = rises_a; bb = rises_b;
      quad(169, 0);
      chk(rises_a - ba == 1, "R1 169 edges /85", rises_a - ba, 1);
      quad(1, 0);
      chk(rises_a - ba == 2, "R1 170 edges /85 A", rises_a - ba, 2);
      chk(rises_b - bb == 2, "R1 170 edges /85 B", rises_b - bb, 2);
   endtask

   task automatic t_divide();
      int ba, bb;
      set_cfg(M_DIV, 3);
      ba = rises_a; bb = rises_b;
      quad(10, 0);
      chk(rises_a - ba == 3, "R2 N=3 fwd A", rises_a - ba, 3);
      chk(rises_b - bb == 3, "R2 N=3 fwd B", rises_b - bb, 3);
      set_cfg(M_DIV, 2);
      ba = rises_a; bb = rises_b;
      quad(6, 1);
      chk(rises_a - ba == 3, "R2 N=2 rev A", rises_a - ba, 3);
      chk(rises_b - bb == 3, "R2 N=2 rev B", rises_b - bb, 3);
      set_cfg(M_DIV, 4);
      quad(3, 0);
      chk(out_a == 1'b0, "R2 N=4 after 3", out_a, 0);
      quad(1, 0);
      chk(out_a == 1'b1, "R2 N=4 after 4", out_a, 1);
      quad(2, 0);
      chk(out_a == 1'b0, "R2 N=4 after 6 (fall at N/2)", out_a, 0);
   endtask

   task automatic t_pass();
      int ba;
      set_cfg(M_DIV, 1);
      ba = rises_a;
      quad(5, 0);
      chk(rises_a - ba == 5, "R3 N=1 pass", rises_a - ba, 5);
      set_cfg(M_DIV, 0);
      ba = rises_a;
      quad(4, 1);
      chk(rises_a - ba == 4, "R3 N=0 pass", rises_a - ba, 4);
   endtask

   task automatic t_latency();
      int seen2, seen3;
      set_cfg(M_DIV, 1);
      @(negedge clk);
      enc_a = 1'b1;
      @(negedge clk); @(negedge clk);
      seen2 = out_a;
      @(negedge clk);
      seen3 = out_a;
      chk(seen2 == 0, "R6 not yet after 2 edges", seen2, 0);
      chk(seen3 == 1, "R6 out after 3 edges", seen3, 1);
      hold();
      enc_a = 1'b0;
      hold();
   endtask

   task automatic t_phase();
      int ba, bb;
      set_cfg(M_PHASE, 2);
      ba = rises_a;
      quad(4, 0);
      chk(rises_a - ba == 2, "R4 A divided", rises_a - ba, 2);
      chk(out_b == 1'b0, "R4 A leads flag", out_b, 0);
      bb = rises_b;
      quad(3, 1);
      chk(out_b == 1'b1, "R4 B leads flag", out_b, 1);
      chk(rises_b - bb == 1, "R4 flag static", rises_b - bb, 1);
      enc_b = 1'b1; hold(); enc_b = 1'b0; hold();
      chk(out_b == 1'b1, "R4 flag holds without A edge", out_b, 1);
      quad(1, 0);
      chk(out_b == 1'b0, "R4 back to A leads", out_b, 0);
   endtask

   task automatic t_dir();
      int ba;
      set_cfg(M_DIR, 2);
      enc_b = 1'b1; hold();
      chk(out_b == 1'b1, "R5 dir high", out_b, 1);
      ba = rises_a;
      pulse_a(4);
      chk(rises_a - ba == 2, "R5 A divided", rises_a - ba, 2);
      enc_b = 1'b0; hold();
      chk(out_b == 1'b0, "R5 dir low", out_b, 0);
      set_cfg(M_DIR2, 2);
      enc_b = 1'b1; hold();
      chk(out_b == 1'b1, "R5 m2 ignored", out_b, 1);
      enc_b = 1'b0; hold();
   endtask

   task automatic t_cfg_clear();
      int ba;
      set_cfg(M_DIV, 4);
      pulse_a(3);
      @(negedge clk);
      ratio_sw_n = ~8'd5; hold();
      ba = rises_a;
      pulse_a(5);
      chk(out_a == 1'b1, "R7 counter cleared", out_a, 1);
      chk(rises_a - ba == 1, "R7 one rise", rises_a - ba, 1);
      set_cfg(M_PHASE, 3);
      quad(1, 1);
      chk(out_b == 1'b1, "R7 flag set", out_b, 1);
      @(negedge clk);
      ratio_sw_n = ~8'd4; hold();
      chk(out_b == 1'b0, "R7 flag cleared", out_b, 0);
   endtask

   task automatic t_srst();
      set_cfg(M_DIV, 3);
      pulse_a(2);
      @(negedge clk); srst = 1'b1;
      @(negedge clk); @(negedge clk); srst = 1'b0;
      hold();
      pulse_a(3);
      chk(out_a == 1'b1, "R8 reset clears count", out_a, 1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #400_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      srst = 1'b0;
      @(negedge clk);
      t_reset();
      t_ratio_decode();
      t_divide();
      t_pass();
      t_latency();
      t_phase();
      t_dir();
      t_cfg_clear();
      t_srst();
      finish_run();
   end

endmodule